// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external 128K x 16 asynchronous static RAM that has separate upper and lower byte lanes. The host presents one request for one cycle: a read or write flag, a word address, write data and a two-bit byte mask. The controller then runs the memory's active-low strobes through a timed sequence and returns a single-cycle completion pulse. Reads also return the captured word.

Every phase length is derived at elaboration from nanosecond limits and the clock period. Each count is a ceiling division with a floor of one cycle, so the same RTL serves other clock rates and speed grades through parameters alone. Writes are controlled by write enable. Output enable stays high during a write. The controller drives the shared data bus only after the memory's output turn-off time has elapsed, and it keeps driving for one cycle after write enable rises.

Top module: `sram_ctl`

## Requirements
- R1: While rst_ni is low, and afterwards until the first request, chip enable, output enable, write enable and both byte enables are high, sram_dq_oe_o is low and done_o is low.
- R2: A read holds chip enable and output enable low and write enable high for max(ceil(T_AA_NS/CLK_PERIOD_NS), ceil(T_RC_NS/CLK_PERIOD_NS)) cycles. be_i bit 0 drives the lower lane enable (data bits 7:0) low and bit 1 drives the upper lane enable (bits 15:8) low. The bus is sampled on the last clock of that window.
- R3: A write keeps output enable high and holds write enable low for at least ceil(T_WP_NS/CLK_PERIOD_NS) cycles. sram_dq_oe_o rises no earlier than max(ceil(T_WZ_NS/P), ceil(T_OHZ_NS/P)) cycles after write enable falls and no earlier than that after output enable rises. Data is driven at least ceil(T_DW_NS/P) cycles before write enable rises and for one cycle after.
- R4: A write occupies at least ceil(T_WC_NS/CLK_PERIOD_NS) cycles from the start of the strobe to completion. With the default parameters, done_o appears 12 cycles after the request cycle for a read or a write.
- R5: done_o is high for one cycle per accepted request. rdata_o changes only together with done_o at the end of a read, and it holds its value across later writes.
- R6: A request with be_i == 0 raises done_o on the next cycle and makes no memory access: chip enable never falls.
- R7: A request presented while an access is in progress is ignored. It causes no extra access and no extra done pulse.
- R8: Output enable and write enable are never low together, and chip enable is never low with both byte enables high.
- R9: sram_addr_o is stable for as long as chip enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, sampled when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rdata_o | output | 16 | Captured read word |
| done_o | output | 1 | One-cycle completion pulse |
| sram_addr_o | output | 17 | Memory address |
| sram_dq_o | output | 16 | Data toward memory |
| sram_dq_oe_o | output | 1 | Tri-state enable for sram_dq_o |
| sram_dq_i | input | 16 | Data from memory |
| sram_ce_no | output | 1 | Chip enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_ub_no | output | 1 | Upper byte enable, active low |
| sram_lb_no | output | 1 | Lower byte enable, active low |

## Verification
The bench builds the block with its defaults: a 5 ns clock against the 55 ns grade. That gives an 11-cycle read window, a 4-cycle turn-off wait, a 5-cycle data phase and a 1-cycle recovery. At this clock every limit falls on a clock boundary exactly, so a phase that is one cycle short surfaces in the nanosecond-resolution memory model. The model catches it as early read data, a short write pulse, short data setup or bus contention. A read that is immediately followed by a write exercises the output-enable turn-off window.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WTURN, ST_WDATA, ST_WHOLD, ST_WREC
  } st_e;

  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int CW       = 4,
  parameter int RD_CYC   = 11,
  parameter int TURN_CYC = 4,
  parameter int DATA_CYC = 5,
  parameter int REC_CYC  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [1:0]    be_i,
  input  logic          expired_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          take_o,
  output logic          cap_o,
  output st_e           st_d_o,
  output logic          done_o
);
  st_e  st_q, st_d;
  logic fin, done_q;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    take_o     = 1'b0;
    cap_o      = 1'b0;
    fin        = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        if (be_i == 2'b00) fin = 1'b1;
        else begin
          take_o = 1'b1;
          load_o = 1'b1;
          if (we_i) begin
            st_d       = ST_WTURN;
            load_val_o = CW'(TURN_CYC - 1);
          end else begin
            st_d       = ST_READ;
            load_val_o = CW'(RD_CYC - 1);
          end
        end
      end
      ST_READ: if (expired_i) begin
        cap_o = 1'b1;
        fin   = 1'b1;
        st_d  = ST_IDLE;
      end
      ST_WTURN: if (expired_i) begin
        st_d       = ST_WDATA;
        load_o     = 1'b1;
        load_val_o = CW'(DATA_CYC - 1);
      end
      ST_WDATA: if (expired_i) begin
        st_d   = ST_WHOLD;
        load_o = 1'b1;
      end
      ST_WHOLD: begin
        st_d       = ST_WREC;
        load_o     = 1'b1;
        load_val_o = CW'(REC_CYC - 1);
      end
      ST_WREC: if (expired_i) begin
        fin  = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= fin;
    end
  end

  assign st_d_o = st_d;
  assign done_o = done_q;

  // R6
  zero_mask_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && req_i && be_i == 2'b00) |=> done_o);
  // R7
  busy_no_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> !take_o);
endmodule

// File: rtl/sram_ctl_pins.sv
`timescale 1ns/1ps
module sram_ctl_pins
  import sram_ctl_pkg::*;
#(
  parameter int AW       = 17,
  parameter int DW       = 16,
  parameter int TURN_CYC = 4,
  parameter int WE_MIN   = 9,
  parameter int CW       = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  st_e           st_d_i,
  input  logic          take_i,
  input  logic          cap_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    be_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          ce_no,
  output logic          oe_no,
  output logic          we_no,
  output logic          ub_no,
  output logic          lb_no
);
  localparam int LCW = CW + 2;

  logic [1:0]  mask_q, mask_d;
  logic        ce_n_d, oe_n_d, we_n_d, dq_oe_d;

  assign mask_d  = take_i ? be_i : mask_q;
  assign ce_n_d  = !(st_d_i inside {ST_READ, ST_WTURN, ST_WDATA, ST_WHOLD});
  assign oe_n_d  = (st_d_i != ST_READ);
  assign we_n_d  = !(st_d_i inside {ST_WTURN, ST_WDATA});
  assign dq_oe_d = (st_d_i inside {ST_WDATA, ST_WHOLD});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      addr_o  <= '0;
      dq_o    <= '0;
      rdata_o <= '0;
      ce_no   <= 1'b1;
      oe_no   <= 1'b1;
      we_no   <= 1'b1;
      ub_no   <= 1'b1;
      lb_no   <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      mask_q <= mask_d;
      if (take_i) begin
        addr_o <= addr_i;
        dq_o   <= wdata_i;
      end
      if (cap_i) rdata_o <= dq_i;
      ce_no   <= ce_n_d;
      oe_no   <= oe_n_d;
      we_no   <= we_n_d;
      lb_no   <= ce_n_d | !mask_d[0];
      ub_no   <= ce_n_d | !mask_d[1];
      dq_oe_o <= dq_oe_d;
    end
  end

  // cycles write enable has been low, saturating; checker use only
  logic [LCW-1:0] we_lo_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  we_lo_cnt <= '0;
    else if (we_no)               we_lo_cnt <= '0;
    else if (we_lo_cnt != '1)     we_lo_cnt <= we_lo_cnt + 1'b1;
  end

  // R8
  oe_we_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_no && !we_no));
  // R8
  lane_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_no |-> !(ub_no && lb_no));
  // R3
  drive_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> oe_no);
  // R3
  turn_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dq_oe_o) |-> (!we_no && we_lo_cnt >= LCW'(TURN_CYC)));
  // R3
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> (we_lo_cnt >= LCW'(WE_MIN) && dq_oe_o));
  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_no && $past(!ce_no)) |-> $stable(addr_o));
endmodule

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW            = 17,
  parameter int DW            = 16,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_WC_NS       = 55,
  parameter int T_WP_NS       = 45,
  parameter int T_DW_NS       = 25,
  parameter int T_WZ_NS       = 20,
  parameter int T_OHZ_NS      = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    be_i,
  output logic [DW-1:0] rdata_o,
  output logic          done_o,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_dq_o,
  output logic          sram_dq_oe_o,
  input  logic [DW-1:0] sram_dq_i,
  output logic          sram_ce_no,
  output logic          sram_oe_no,
  output logic          sram_we_no,
  output logic          sram_ub_no,
  output logic          sram_lb_no
);
  localparam int RD_CYC   = imax(ns2cyc(T_AA_NS, CLK_PERIOD_NS), ns2cyc(T_RC_NS, CLK_PERIOD_NS));
  localparam int TURN_CYC = imax(ns2cyc(T_WZ_NS, CLK_PERIOD_NS), ns2cyc(T_OHZ_NS, CLK_PERIOD_NS));
  localparam int DATA_CYC = imax(imax(ns2cyc(T_DW_NS, CLK_PERIOD_NS),
                                      ns2cyc(T_WP_NS, CLK_PERIOD_NS) - TURN_CYC), 1);
  localparam int REC_CYC  = imax(ns2cyc(T_WC_NS, CLK_PERIOD_NS) - TURN_CYC - DATA_CYC - 1, 1);
  localparam int MAX_CYC  = imax(imax(RD_CYC, TURN_CYC), imax(DATA_CYC, REC_CYC));
  localparam int CW       = $clog2(MAX_CYC + 1);

  logic          load, take, cap, expired;
  logic [CW-1:0] load_val;
  st_e           st_d;

  sram_ctl_timer #(.CW(CW)) u_timer (
    .clk_i, .rst_ni,
    .load_i(load), .val_i(load_val), .expired_o(expired)
  );

  sram_ctl_seq #(
    .CW(CW), .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC),
    .DATA_CYC(DATA_CYC), .REC_CYC(REC_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .req_i, .we_i, .be_i,
    .expired_i(expired), .load_o(load), .load_val_o(load_val),
    .take_o(take), .cap_o(cap), .st_d_o(st_d), .done_o
  );

  sram_ctl_pins #(
    .AW(AW), .DW(DW), .TURN_CYC(TURN_CYC),
    .WE_MIN(TURN_CYC + DATA_CYC), .CW(CW)
  ) u_pins (
    .clk_i, .rst_ni, .st_d_i(st_d), .take_i(take), .cap_i(cap),
    .addr_i, .wdata_i, .be_i, .dq_i(sram_dq_i), .rdata_o,
    .addr_o(sram_addr_o), .dq_o(sram_dq_o), .dq_oe_o(sram_dq_oe_o),
    .ce_no(sram_ce_no), .oe_no(sram_oe_no), .we_no(sram_we_no),
    .ub_no(sram_ub_no), .lb_no(sram_lb_no)
  );

  // R5
  rdata_only_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> done_o);
endmodule

// File: tb/sram_ctl_tb.sv
`timescale 1ns/1ps
module sram_ctl_tb;
  localparam int P = 5;
  function automatic int cdiv(input int ns);
    int c;
    c = (ns + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction
  // expected latency (request cycle to done sample), from the requirements
  localparam int LAT_RD = cdiv(55) + 1;
  localparam int LAT_WR = cdiv(55) + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic [15:0] rdata, dq_o, dq_i;
  logic [16:0] s_addr;
  logic done, dq_oe, ce_n, oe_n, we_n, ub_n, lb_n;

  always #2.5 clk = ~clk;

  sram_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .rdata_o(rdata), .done_o(done),
    .sram_addr_o(s_addr), .sram_dq_o(dq_o), .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i),
    .sram_ce_no(ce_n), .sram_oe_no(oe_n), .sram_we_no(we_n),
    .sram_ub_no(ub_n), .sram_lb_no(lb_n)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req_tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [15:0] sram [int];
  logic [15:0] ref_mem [int];
  realtime t_act = 0, t_oe_rise = -1000, t_we_fall = -1000, t_dq = 0;
  int viol = 0, cont = 0, ce_falls = 0;
  logic [15:0] model_q = 16'h0;
  assign dq_i = model_q;

  always @(s_addr, ce_n, oe_n, we_n, ub_n, lb_n) t_act = $realtime;
  always @(posedge oe_n) t_oe_rise = $realtime;
  always @(negedge we_n) t_we_fall = $realtime;
  always @(negedge ce_n) if (rst_n) ce_falls++;
  always @(dq_o, posedge dq_oe) t_dq = $realtime;

  always @(posedge we_n) begin
    if (ce_n === 1'b0 && rst_n) begin
      logic [15:0] w;
      if ($realtime - t_we_fall < 45.0) viol++;
      if ($realtime - t_dq < 25.0 || dq_oe !== 1'b1) viol++;
      w = sram.exists(int'(s_addr)) ? sram[int'(s_addr)] : 16'h0;
      if (lb_n === 1'b0) w[7:0]  = dq_o[7:0];
      if (ub_n === 1'b0) w[15:8] = dq_o[15:8];
      sram[int'(s_addr)] = w;
    end
  end

  always #1 begin
    realtime now;
    logic [15:0] word;
    bit drv;
    now  = $realtime;
    drv  = (ce_n === 1'b0 && oe_n === 1'b0 && we_n === 1'b1 && !(ub_n === 1'b1 && lb_n === 1'b1));
    word = sram.exists(int'(s_addr)) ? sram[int'(s_addr)] : 16'h0;
    if (dq_oe === 1'b1 && (drv || now - t_oe_rise < 20.0 || now - t_we_fall < 20.0)) cont++;
    model_q = (drv && now - t_act >= 54.0) ? word : ~word;
  end

  // ---------------- stimulus ----------------
  logic [15:0] last_rd = '0;

  task automatic access(input bit w, input logic [16:0] a, input logic [15:0] d,
                        input logic [1:0] m, input bit poke);
    int lat;
    logic [15:0] lm, e;
    lat = (m == 2'b00) ? 1 : (w ? LAT_WR : LAT_RD);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; be = m;
    @(negedge clk);
    req = 1'b0;
    for (int n = 1; n <= lat; n++) begin
      chk(done === (n == lat), w ? "R4 done timing" : "R2 done timing", {31'd0, done}, {31'd0, n == lat});
      if (n == 2 && m != 2'b00) begin
        if (w) chk(oe_n === 1'b1 && we_n === 1'b0, "R3 write strobes", {oe_n, we_n}, 2'b10);
        else   chk(oe_n === 1'b0 && we_n === 1'b1 && lb_n === !m[0] && ub_n === !m[1],
                   "R2 read strobes", {oe_n, we_n, ub_n, lb_n}, {2'b01, !m[1], !m[0]});
      end
      if (poke && n == 3) begin
        req = 1'b1; we = ~w; addr = a ^ 17'h1; wdata = ~d; be = 2'b11;
      end else req = 1'b0;
      if (n < lat) @(negedge clk);
    end
    req = 1'b0;
    @(negedge clk);
    chk(done === 1'b0, "R5 single done", {31'd0, done}, 32'd0);
    lm = {{8{m[1]}}, {8{m[0]}}};
    if (w) begin
      e = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0;
      ref_mem[int'(a)] = (e & ~lm) | (d & lm);
      chk(rdata === last_rd, "R5 rdata held over write", {16'd0, rdata}, {16'd0, last_rd});
    end else if (m != 2'b00) begin
      e = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0;
      chk((rdata & lm) === (e & lm), "R2 read data", {16'd0, rdata & lm}, {16'd0, e & lm});
      last_rd = rdata;
    end
  endtask

  initial begin
    #(200000 * P);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cf;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({ce_n, oe_n, we_n, ub_n, lb_n} === 5'b11111 && dq_oe === 1'b0 && done === 1'b0,
        "R1 reset", {25'd0, ce_n, oe_n, we_n, ub_n, lb_n, dq_oe, done}, 32'h7C);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({ce_n, oe_n, we_n, ub_n, lb_n} === 5'b11111 && dq_oe === 1'b0, "R1 idle after reset",
        {26'd0, ce_n, oe_n, we_n, ub_n, lb_n, dq_oe}, 32'h3E);

    access(1, 17'h00010, 16'hAAAA, 2'b11, 0);
    access(1, 17'h1FFFF, 16'h1234, 2'b11, 0);
    access(1, 17'h00000, 16'hFFFF, 2'b11, 0);
    access(0, 17'h00010, 16'h0, 2'b11, 0);
    access(1, 17'h00010, 16'h005A, 2'b01, 0);     // lower lane only
    access(0, 17'h00010, 16'h0, 2'b11, 0);
    access(1, 17'h1FFFF, 16'hC300, 2'b10, 0);     // upper lane only
    access(0, 17'h1FFFF, 16'h0, 2'b10, 0);
    access(0, 17'h1FFFF, 16'h0, 2'b01, 0);
    // read immediately followed by write: output-enable turn-off window
    access(0, 17'h00000, 16'h0, 2'b11, 0);
    access(1, 17'h00001, 16'h0F0F, 2'b11, 0);
    access(0, 17'h00001, 16'h0, 2'b11, 0);
    access(1, 17'h00002, 16'h8001, 2'b11, 0);
    access(0, 17'h00002, 16'h0, 2'b11, 0);

    // R6 zero mask: no access, no data change
    cf = ce_falls;
    access(1, 17'h00010, 16'h0000, 2'b00, 0);
    access(0, 17'h00010, 16'h0000, 2'b00, 0);
    chk(ce_falls == cf, "R6 no access on zero mask", cf, ce_falls);
    access(0, 17'h00010, 16'h0, 2'b11, 0);

    // R7 request during busy is ignored
    cf = ce_falls;
    access(1, 17'h00020, 16'h7777, 2'b11, 1);
    chk(ce_falls == cf + 1, "R7 single access while busy", ce_falls, cf + 1);
    access(0, 17'h00021, 16'h0, 2'b11, 0);       // poke target left untouched
    access(0, 17'h00020, 16'h0, 2'b11, 0);

    repeat (20) @(negedge clk);
    chk(viol == 0, "R3 write timing at memory", viol, 0);
    chk(cont == 0, "R3 bus contention", cont, 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule